// File: doc/BRIEF.md
# Shift, Rotate and Byte-Swap Unit

This combinational unit sits on the internal bus of a small 16-bit processor. It takes one operand word and the current carry flag. A 2-bit operation code picks one of four results: the operand unchanged, the operand shifted right by one with a zero filled in at the top, the operand rotated right through the carry flag, or the operand with its two bytes exchanged. The bit that leaves the bottom of the word during a shift or rotate comes out on a separate shift-out line.

The unit also does two jobs for the status register. It chooses the carry to be stored next, either its own shift-out bit or the carry-out of an external adder, under a select input. It flags whether the word currently on the bus is all zeros. It also provides the sign of its result. The adder, the bus drivers and the flag storage sit outside the unit.

Top module: `shrot_unit`

## Requirements
- R1: With op_i = 2'b00 (pass), result_o equals operand_i and shift_out_o is 0.
- R2: With op_i = 2'b01 (logical shift right), result_o[14:0] equals operand_i[15:1], result_o[15] is 0, and shift_out_o equals operand_i[0].
- R3: With op_i = 2'b10 (rotate right through carry), result_o[15] equals carry_flag_i, result_o[14:0] equals operand_i[15:1], and shift_out_o equals operand_i[0].
- R4: With op_i = 2'b11 (byte swap), result_o[15:8] equals operand_i[7:0], result_o[7:0] equals operand_i[15:8], and shift_out_o is 0.
- R5: carry_next_o equals shift_out_o when carry_sel_i is 0, and equals adder_cout_i when carry_sel_i is 1.
- R6: zero_o is 1 exactly when all 16 bits of bus_word_i are 0. It does not depend on the operand or the operation.
- R7: sign_o equals result_o[15].
- R8: For op_i values 2'b00, 2'b01 and 2'b11, carry_flag_i has no effect on result_o or shift_out_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 16 | Operand word |
| carry_flag_i | input | 1 | Current carry flag, shifted in by the rotate |
| op_i | input | 2 | Operation code: 00 pass, 01 shift right, 10 rotate right through carry, 11 byte swap |
| adder_cout_i | input | 1 | Carry-out from the external adder |
| carry_sel_i | input | 1 | Carry source for the status register: 0 shift-out, 1 adder |
| bus_word_i | input | 16 | Word currently on the internal bus |
| result_o | output | 16 | Result of the selected operation |
| shift_out_o | output | 1 | Bit shifted out of bit 0 (0 for pass and swap) |
| carry_next_o | output | 1 | Carry value offered to the status register |
| sign_o | output | 1 | Bit 15 of the result |
| zero_o | output | 1 | High when bus_word_i is all zeros |

## Verification
On every settled evaluation, the assertions check each operation's bit mapping against the operand, the fixed shift-out for pass and swap, the carry-source multiplexing, the zero flag against the bus word and the sign against the result. Only the bench scenarios can show the edge patterns that matter: the incoming carry reaching bit 15 only in the rotate, all-ones and all-zeros operands, the lone set bits at either end of the bus word, and a carry toggle that leaves the other three operations untouched.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned HALF_W = WORD_W / 2;

    typedef enum logic [1:0] {
        OP_PASS   = 2'b00,
        OP_SHR    = 2'b01,
        OP_ROR    = 2'b10,
        OP_BSWAP  = 2'b11
    } shrot_op_e;
endpackage

// File: rtl/shrot_datapath.sv
module shrot_datapath
    import shrot_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic [W-1:0] opnd,
    input  logic         cin,
    input  shrot_op_e    op,
    output logic [W-1:0] res,
    output logic         sout
);
    localparam int unsigned H = W / 2;

    logic [W-1:0] swapped;
    logic         top_fill;

    // Byte exchange built bit by bit: lower half moves up, upper half moves down.
    for (genvar i = 0; i < H; i++) begin : g_swap
        assign swapped[i + H] = opnd[i];
        assign swapped[i]     = opnd[i + H];
    end

    always_comb begin
        top_fill = 1'b0;
        res      = opnd;
        sout     = 1'b0;
        unique case (op)
            OP_PASS: begin
                res  = opnd;
                sout = 1'b0;
            end
            OP_SHR: begin
                top_fill = 1'b0;
                res      = {top_fill, opnd[W-1:1]};
                sout     = opnd[0];
            end
            OP_ROR: begin
                top_fill = cin;
                res      = {top_fill, opnd[W-1:1]};
                sout     = opnd[0];
            end
            OP_BSWAP: begin
                res  = swapped;
                sout = 1'b0;
            end
            default: begin
                res  = opnd;
                sout = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] bus_word,
    input  logic [W-1:0] res,
    input  logic         sout,
    input  logic         add_cout,
    input  logic         sel_adder,
    output logic         carry_next,
    output logic         sign,
    output logic         zero
);
    always_comb begin
        carry_next = sel_adder ? add_cout : sout;
        sign       = res[W-1];
        zero       = ~(|bus_word);
    end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
(
    input  logic [15:0] operand_i,
    input  logic        carry_flag_i,
    input  logic [1:0]  op_i,
    input  logic        adder_cout_i,
    input  logic        carry_sel_i,
    input  logic [15:0] bus_word_i,
    output logic [15:0] result_o,
    output logic        shift_out_o,
    output logic        carry_next_o,
    output logic        sign_o,
    output logic        zero_o
);
    shrot_op_e op_dec;
    assign op_dec = shrot_op_e'(op_i);

    shrot_datapath #(.W(WORD_W)) u_dp (
        .opnd (operand_i),
        .cin  (carry_flag_i),
        .op   (op_dec),
        .res  (result_o),
        .sout (shift_out_o)
    );

    shrot_flags #(.W(WORD_W)) u_fl (
        .bus_word   (bus_word_i),
        .res        (result_o),
        .sout       (shift_out_o),
        .add_cout   (adder_cout_i),
        .sel_adder  (carry_sel_i),
        .carry_next (carry_next_o),
        .sign       (sign_o),
        .zero       (zero_o)
    );
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk (
    input logic [15:0] operand_i,
    input logic        carry_flag_i,
    input logic [1:0]  op_i,
    input logic        adder_cout_i,
    input logic        carry_sel_i,
    input logic [15:0] bus_word_i,
    input logic [15:0] result_o,
    input logic        shift_out_o,
    input logic        carry_next_o,
    input logic        sign_o,
    input logic        zero_o
);
    always_comb begin
        if (op_i == 2'b00) begin
            assert_pass_R1: assert (result_o == operand_i && !shift_out_o)
                else $error("R1 pass mapping broken");
        end
        if (op_i == 2'b01) begin
            assert_shr_R2: assert (!result_o[15] && result_o[14:0] == operand_i[15:1]
                                   && shift_out_o == operand_i[0])
                else $error("R2 shift mapping broken");
        end
        if (op_i == 2'b10) begin
            assert_ror_R3: assert (result_o[15] == carry_flag_i
                                   && result_o[14:0] == operand_i[15:1]
                                   && shift_out_o == operand_i[0])
                else $error("R3 rotate mapping broken");
        end
        if (op_i == 2'b11) begin
            assert_swap_R4: assert (result_o[15:8] == operand_i[7:0]
                                    && result_o[7:0] == operand_i[15:8] && !shift_out_o)
                else $error("R4 swap mapping broken");
        end
        assert_csel_R5: assert (carry_next_o == (carry_sel_i ? adder_cout_i : shift_out_o))
            else $error("R5 carry source wrong");
        assert_zero_R6: assert (zero_o == (bus_word_i == 16'h0000))
            else $error("R6 zero flag wrong");
        assert_sign_R7: assert (sign_o == result_o[15])
            else $error("R7 sign wrong");
        if (op_i != 2'b10) begin
            assert_cin_ignored_R8: assert (result_o[15] == (op_i == 2'b00 ? operand_i[15] :
                                           op_i == 2'b11 ? operand_i[7] : 1'b0))
                else $error("R8 carry leaked into result");
        end
    end
endmodule

bind shrot_unit shrot_unit_chk u_chk (
    .operand_i    (operand_i),
    .carry_flag_i (carry_flag_i),
    .op_i         (op_i),
    .adder_cout_i (adder_cout_i),
    .carry_sel_i  (carry_sel_i),
    .bus_word_i   (bus_word_i),
    .result_o     (result_o),
    .shift_out_o  (shift_out_o),
    .carry_next_o (carry_next_o),
    .sign_o       (sign_o),
    .zero_o       (zero_o)
);

// File: tb/sim_shrot_unit.sv
`timescale 1ns/1ps
module sim_shrot_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] operand_i = '0;
    logic        carry_flag_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic        adder_cout_i = 1'b0;
    logic        carry_sel_i = 1'b0;
    logic [15:0] bus_word_i = '0;
    logic [15:0] result_o;
    logic        shift_out_o, carry_next_o, sign_o, zero_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    shrot_unit u0 (
        .operand_i(operand_i), .carry_flag_i(carry_flag_i), .op_i(op_i),
        .adder_cout_i(adder_cout_i), .carry_sel_i(carry_sel_i),
        .bus_word_i(bus_word_i), .result_o(result_o), .shift_out_o(shift_out_o),
        .carry_next_o(carry_next_o), .sign_o(sign_o), .zero_o(zero_o)
    );

    // Vector fields: {op, cin, operand, expected result, expected shift-out}
    localparam int NV = 8;
    localparam logic [1:0]  V_OP  [NV] = '{2'b00, 2'b01, 2'b01, 2'b10, 2'b10, 2'b10, 2'b11, 2'b11};
    localparam logic        V_CIN [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam logic [15:0] V_OPD [NV] = '{16'hA5C3, 16'h8001, 16'hFFFE, 16'h0001,
                                           16'h1234, 16'hFFFF, 16'h1234, 16'h00FF};
    localparam logic [15:0] V_RES [NV] = '{16'hA5C3, 16'h4000, 16'h7FFF, 16'h8000,
                                           16'h091A, 16'h7FFF, 16'h3412, 16'hFF00};
    localparam logic        V_SO  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam string       V_REQ [NV] = '{"R1", "R2", "R2", "R3", "R3", "R3", "R4", "R4"};

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic cin, input logic [15:0] opd);
        @(negedge clk);
        op_i = op; carry_flag_i = cin; operand_i = opd;
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected done", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] r_ref;
        logic        s_ref;
        // Initial state: all-zero inputs give zero result and zero flag (R1, R6)
        #1;
        check("R1", result_o, 16'h0000);
        check("R6", {15'b0, zero_o}, 16'h0001);
        repeat (2) @(posedge clk);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            apply(V_OP[k], V_CIN[k], V_OPD[k]);
            check(V_REQ[k], result_o, V_RES[k]);
            check(V_REQ[k], {15'b0, shift_out_o}, {15'b0, V_SO[k]});
            check("R7", {15'b0, sign_o}, {15'b0, V_RES[k][15]});
        end

        // R5: carry source selection
        apply(2'b01, 1'b0, 16'h0003);
        carry_sel_i = 1'b0; adder_cout_i = 1'b0; #1;
        check("R5", {15'b0, carry_next_o}, 16'h0001);
        carry_sel_i = 1'b1; #1;
        check("R5", {15'b0, carry_next_o}, 16'h0000);
        adder_cout_i = 1'b1; apply(2'b11, 1'b0, 16'h0003);
        check("R5", {15'b0, carry_next_o}, 16'h0001);
        carry_sel_i = 1'b0; #1;
        check("R5", {15'b0, carry_next_o}, 16'h0000);

        // R6: zero detection on the bus word, independent of the operand
        operand_i = 16'h0000; bus_word_i = 16'h0001; #1;
        check("R6", {15'b0, zero_o}, 16'h0000);
        bus_word_i = 16'h8000; #1;
        check("R6", {15'b0, zero_o}, 16'h0000);
        operand_i = 16'hFFFF; bus_word_i = 16'h0000; #1;
        check("R6", {15'b0, zero_o}, 16'h0001);
        bus_word_i = 16'hFFFF; #1;
        check("R6", {15'b0, zero_o}, 16'h0000);

        // R8: carry flag toggled under pass, shift and swap changes nothing
        for (int m = 0; m < 3; m++) begin
            logic [1:0] op_m;
            op_m = (m == 0) ? 2'b00 : (m == 1) ? 2'b01 : 2'b11;
            apply(op_m, 1'b0, 16'h6B2D);
            r_ref = result_o; s_ref = shift_out_o;
            carry_flag_i = 1'b1; #1;
            check("R8", result_o, r_ref);
            check("R8", {15'b0, shift_out_o}, {15'b0, s_ref});
        end

        // R3 corner: rotate with carry set and zero operand lands only bit 15; R7 sign follows
        apply(2'b10, 1'b1, 16'h0000);
        check("R3", result_o, 16'h8000);
        check("R7", {15'b0, sign_o}, 16'h0001);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule